// File: doc/BRIEF.md
# T1 Transmit Frame Synchronizer

This block finds the T1 frame alignment of the serial stream arriving at a transmitter when no external frame-sync pulse is supplied. It samples one data bit on every cycle that the bit-enable input is high. It keeps a short history for every one of the 386 bit phases of a two-frame period. The first phase that shows the alternating terminal-framing pattern often enough is taken as the framing-bit position. From then on, a flywheel counter gives the downstream transmit framer a frame-start strobe and the position of the next bit.

The host controls the block with three inputs. An enable turns synchronization on. While it is off, the position counter simply runs freely from reset. A second input stops the block from searching again by itself when alignment is lost. A manual resync request acts only on its rising edge. A real-time flag shows when a search is under way, and a latched flag records that a search has occurred until the host clears it.

Top module: `t1_tx_frame_sync`

## Requirements
- R1: After reset, `bit_pos` is 0, `frame_start` is 1, and `lof` and `lofd` are 0. `bit_pos` names the position (0 to 192) of the next bit to be consumed, where 0 is the framing bit. `frame_start` is high exactly when `bit_pos` is 0.
- R2: While `sync_en` is low, `lof` stays low and `bit_pos` counts consumed bits modulo 193 from reset.
- R3: The cycle after `sync_en` is seen high while the block is idle, `lof` is high (a search starts).
- R4: During a search, a bit phase of the 386-bit two-frame period is accepted once its samples have alternated in value 6 times in a row. From then on, `bit_pos` equals the true position of the next bit in the stream.
- R5: While aligned, the framing bits of alternate frames must follow a 1,0,1,0 pattern. When 2 of the last 4 such bits are wrong and `auto_off` is 0, a new search starts.
- R6: With `auto_off` at 1, loss of alignment starts no search: `lof` stays low and `bit_pos` keeps counting on the old alignment.
- R7: A rising edge of `resync_req` while enabled starts a search the next cycle. Holding `resync_req` high starts no further search. The request must fall and rise again to start another one.
- R8: `lof` is high in exactly those cycles in which a search is in progress.
- R9: `lofd` goes high the cycle after any cycle with `lof` high and stays high until cleared. `lofd_clr` clears it on the next cycle, unless `lof` is high in the cycle of the clear; in that case `lofd` stays set.
- R10: A cycle with `bit_en` low consumes no bit: `bit_pos` and the search state do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Consume `ser_in` this cycle |
| ser_in | input | 1 | Serial transmit data bit |
| sync_en | input | 1 | Synchronizer enable |
| auto_off | input | 1 | 1 = no automatic search after loss of alignment |
| resync_req | input | 1 | Manual resync, acts on its rising edge |
| lofd_clr | input | 1 | Clears the latched detect flag |
| frame_start | output | 1 | Next bit is the framing bit |
| bit_pos | output | 8 | Position of the next bit within the frame |
| lof | output | 1 | Search in progress (real time) |
| lofd | output | 1 | Latched: a search has occurred |

## Verification
The bench feeds four payload styles: all ones, all zeros, a per-channel count, and a scrambled count. Each is paired with a different framing offset, and one pair is fed at half bit rate. The uniform payloads show that the search accepts no phase that merely holds a steady value. The count-based payloads show that varying channel data does not create a false framing phase, and the gapped feed shows that idle cycles leave the count untouched. Each offset change makes the locked block see a bad framing pattern. This tests loss detection and the automatic return to search, and the same shift with automatic resync disabled shows that the flywheel holds the old alignment.

// File: rtl/t1ts_pkg.sv
package t1ts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_t;
endpackage

// File: rtl/t1ts_phase_hunt.sv
// Per-phase alternation history across a two-frame period; flags a phase
// whose samples alternated LOCK_HITS times in a row.
module t1ts_phase_hunt #(
  parameter int FRAME_BITS = 193,
  parameter int LOCK_HITS  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic ser_in,
  output logic hit
);
  localparam int PHASES = 2 * FRAME_BITS;
  localparam int PW     = $clog2(PHASES);
  localparam int CW     = $clog2(LOCK_HITS + 1);

  logic [PW-1:0] ptr_q;
  logic          warm_q;
  logic [CW:0]   hist_mem [PHASES];
  logic [CW:0]   rd_word;
  logic [CW-1:0] cnt_nx;

  assign rd_word = hist_mem[ptr_q];

  always_comb begin
    if (!warm_q) begin
      cnt_nx = '0;
    end else if (ser_in != rd_word[CW]) begin
      if (rd_word[CW-1:0] >= CW'(LOCK_HITS)) cnt_nx = CW'(LOCK_HITS);
      else                                   cnt_nx = rd_word[CW-1:0] + 1'b1;
    end else begin
      cnt_nx = '0;
    end
  end

  assign hit = bit_en && warm_q && (cnt_nx == CW'(LOCK_HITS));

  always_ff @(posedge clk) begin
    if (bit_en) hist_mem[ptr_q] <= {ser_in, cnt_nx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      warm_q <= 1'b0;
    end else if (bit_en) begin
      if (ptr_q == PW'(PHASES - 1)) begin
        ptr_q  <= '0;
        warm_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/t1ts_frame_cnt.sv
// Flywheel bit-position counter with realignment.
module t1ts_frame_cnt #(
  parameter int FRAME_BITS = 193,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             realign,
  output logic [POS_W-1:0] bit_pos,
  output logic             ft_frame,
  output logic             frame_start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_pos     <= '0;
      ft_frame    <= 1'b1;
      frame_start <= 1'b1;
    end else if (bit_en) begin
      if (realign) begin
        bit_pos     <= POS_W'(1);
        ft_frame    <= 1'b1;
        frame_start <= 1'b0;
      end else if (bit_pos == POS_W'(FRAME_BITS - 1)) begin
        bit_pos     <= '0;
        ft_frame    <= ~ft_frame;
        frame_start <= 1'b1;
      end else begin
        bit_pos     <= bit_pos + 1'b1;
        frame_start <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/t1ts_loss_mon.sv
// Sliding window of terminal-framing errors while aligned.
module t1ts_loss_mon #(
  parameter int LOSS_WIN = 4,
  parameter int LOSS_LIM = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic check,
  input  logic init,
  input  logic clr,
  input  logic ser_in,
  output logic loss
);
  logic [LOSS_WIN-1:0] win_q;
  logic [LOSS_WIN-1:0] win_nx;
  logic                exp_q;

  assign win_nx = {win_q[LOSS_WIN-2:0], ser_in != exp_q};
  assign loss   = check && ($countones(win_nx) >= LOSS_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
      exp_q <= 1'b0;
    end else if (init) begin
      win_q <= '0;
      exp_q <= ~ser_in;
    end else if (clr) begin
      win_q <= '0;
    end else if (check) begin
      exp_q <= ~exp_q;
      win_q <= loss ? '0 : win_nx;
    end
  end
endmodule

// File: rtl/t1_tx_frame_sync.sv
module t1_tx_frame_sync #(
  parameter int FRAME_BITS = 193,
  parameter int LOCK_HITS  = 6,
  parameter int LOSS_WIN   = 4,
  parameter int LOSS_LIM   = 2,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             ser_in,
  input  logic             sync_en,
  input  logic             auto_off,
  input  logic             resync_req,
  input  logic             lofd_clr,
  output logic             frame_start,
  output logic [POS_W-1:0] bit_pos,
  output logic             lof,
  output logic             lofd
);
  import t1ts_pkg::*;

  sync_state_t state_q, state_nx;
  logic req_q, req_edge, hit, loss, realign, ft_frame, check;

  assign req_edge = resync_req && !req_q;
  assign realign  = sync_en && (state_q == ST_SEARCH) && hit && !req_edge;
  assign check    = bit_en && (state_q == ST_LOCKED) && (bit_pos == '0) && ft_frame;

  t1ts_phase_hunt #(.FRAME_BITS(FRAME_BITS), .LOCK_HITS(LOCK_HITS)) hunt_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .hit(hit)
  );

  t1ts_frame_cnt #(.FRAME_BITS(FRAME_BITS)) cnt_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .realign(realign),
    .bit_pos(bit_pos), .ft_frame(ft_frame), .frame_start(frame_start)
  );

  t1ts_loss_mon #(.LOSS_WIN(LOSS_WIN), .LOSS_LIM(LOSS_LIM)) mon_i (
    .clk(clk), .rst(rst), .check(check), .init(realign),
    .clr(state_q != ST_LOCKED), .ser_in(ser_in), .loss(loss)
  );

  always_comb begin
    state_nx = state_q;
    if (!sync_en) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   state_nx = ST_SEARCH;
        ST_SEARCH: if (realign) state_nx = ST_LOCKED;
        ST_LOCKED: if (req_edge || (loss && !auto_off)) state_nx = ST_SEARCH;
        default:   state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      lofd    <= 1'b0;
    end else begin
      state_q <= state_nx;
      req_q   <= resync_req;
      if (state_q == ST_SEARCH) lofd <= 1'b1;
      else if (lofd_clr)        lofd <= 1'b0;
    end
  end

  assign lof = (state_q == ST_SEARCH);
endmodule

// File: rtl/t1ts_checker.sv
module t1ts_checker #(
  parameter int FRAME_BITS = 193,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             sync_en,
  input logic             auto_off,
  input logic             resync_req,
  input logic             lofd_clr,
  input logic             frame_start,
  input logic [POS_W-1:0] bit_pos,
  input logic             lof,
  input logic             lofd
);
  logic req_q, en_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      req_q <= resync_req;
      en_q  <= sync_en;
    end
  end

  assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
    bit_pos < POS_W'(FRAME_BITS));
  assert_start_flag_R1: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (bit_pos == '0));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> !lof);
  assert_hold_pos_R10: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(bit_pos));
  assert_latch_set_R9: assert property (@(posedge clk) disable iff (rst)
    lof |=> lofd);
  assert_latch_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (lofd_clr && !lof) |=> !lofd);
  // R6 and R7: with auto resync off, only an enable or request edge can start a search
  assert_no_self_search_R6: assert property (@(posedge clk) disable iff (rst)
    (auto_off && sync_en && en_q && !lof && !(resync_req && !req_q)) |=> !lof);
endmodule

bind t1_tx_frame_sync t1ts_checker #(.FRAME_BITS(FRAME_BITS)) chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .sync_en(sync_en), .auto_off(auto_off),
  .resync_req(resync_req), .lofd_clr(lofd_clr), .frame_start(frame_start),
  .bit_pos(bit_pos), .lof(lof), .lofd(lofd)
);

// File: tb/t1_tx_frame_sync_tb.sv
module t1_tx_frame_sync_tb_top;
  localparam int FB = 193;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, ser_in = 1'b0, sync_en = 1'b0, auto_off = 1'b0;
  logic resync_req = 1'b0, lofd_clr = 1'b0;
  logic frame_start, lof, lofd;
  logic [7:0] bit_pos;

  always #2.5 clk = ~clk;

  t1_tx_frame_sync dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in), .sync_en(sync_en),
    .auto_off(auto_off), .resync_req(resync_req), .lofd_clr(lofd_clr),
    .frame_start(frame_start), .bit_pos(bit_pos), .lof(lof), .lofd(lofd)
  );

  // {offset[11:4], payload kind[3:2], gapped feed[1], spare[0]}
  localparam logic [11:0] VECS [4] = '{
    {8'd57,  2'd0, 1'b0, 1'b0},
    {8'd120, 2'd1, 1'b1, 1'b0},
    {8'd5,   2'd2, 1'b0, 1'b0},
    {8'd190, 2'd3, 1'b0, 1'b0}
  };

  int nchk = 0, nfail = 0;
  int k = 0, off = 0, kind = 0, expoff = 0;
  bit track = 1'b0;
  int trk_bad = 0, fs_bad = 0, lof_hi = 0;
  bit done = 1'b0;

  function automatic logic bitval(int d, int knd);
    int f, p, ch;
    logic [7:0] by;
    f = d / FB;
    p = d % FB;
    if (p == 0) begin
      if (f % 2 == 0) return ((f / 2) % 2 == 0);
      case ((f / 2) % 6)
        2, 3, 4: return 1'b1;
        default: return 1'b0;
      endcase
    end
    ch = (p - 1) / 8;
    case (knd)
      0: by = 8'hFF;
      1: by = 8'h00;
      2: by = 8'(ch);
      default: by = 8'hA5 ^ 8'(ch * 3);
    endcase
    return by[7 - ((p - 1) % 8)];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clk_bit(input bit en);
    int e;
    @(negedge clk);
    if (track) begin
      e = (k + expoff) % FB;
      if (int'(bit_pos) != e) trk_bad++;
      if (frame_start != (e == 0)) fs_bad++;
      if (lof) lof_hi++;
    end
    bit_en = en;
    if (en) begin
      ser_in = bitval(k + off, kind);
      k++;
    end
  endtask

  task automatic run_bits(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      clk_bit(1'b1);
      if (gap) clk_bit(1'b0);
    end
  endtask

  task automatic start_track(input int eo);
    expoff = eo; trk_bad = 0; fs_bad = 0; lof_hi = 0; track = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset bit_pos", int'(bit_pos), 0);
    chk("R1 reset frame_start", int'(frame_start), 1);
    chk("R1 reset lof", int'(lof), 0);
    chk("R1 reset lofd", int'(lofd), 0);

    // R2: disabled, free-running count from reset
    start_track(0);
    run_bits(300, 1'b0);
    track = 1'b0;
    chk("R2 free-run position errors", trk_bad, 0);
    chk("R2 lof while disabled", lof_hi, 0);
    chk("R1 frame_start errors in free run", fs_bad, 0);

    // R3: enable starts a search
    sync_en = 1'b1;
    clk_bit(1'b0);
    chk("R3 lof after enable", int'(lof), 1);
    chk("R9 lofd one cycle later not yet", int'(lofd), 0);
    clk_bit(1'b0);
    chk("R9 lofd set after lof", int'(lofd), 1);
    lofd_clr = 1'b1;
    clk_bit(1'b0);
    lofd_clr = 1'b0;
    chk("R9 set wins over clear while searching", int'(lofd), 1);

    // Vector table: offset shift, payload style, feed rate
    for (int v = 0; v < 4; v++) begin
      off  = int'(VECS[v][11:4]);
      kind = int'(VECS[v][3:2]);
      run_bits(6000, VECS[v][1]);
      chk($sformatf("R4 lock reached vec%0d", v), int'(lof), 0);
      chk($sformatf("R5 search recorded vec%0d", v), int'(lofd), 1);
      start_track(off);
      run_bits(400, VECS[v][1]);
      track = 1'b0;
      chk($sformatf("R4 position tracking vec%0d", v), trk_bad, 0);
      chk($sformatf("R1 frame_start vec%0d", v), fs_bad, 0);
      chk($sformatf("R8 lof stays low when aligned vec%0d", v), lof_hi, 0);
      if (VECS[v][1]) chk("R10 gapped feed tracking", trk_bad, 0);
      lofd_clr = 1'b1;
      clk_bit(1'b0);
      lofd_clr = 1'b0;
      chk($sformatf("R9 clear when aligned vec%0d", v), int'(lofd), 0);
    end

    // R7: manual resync, edge triggered
    resync_req = 1'b1;
    clk_bit(1'b0);
    chk("R7 lof after request edge", int'(lof), 1);
    run_bits(600, 1'b0);
    chk("R7 relock after request", int'(lof), 0);
    start_track(off);
    run_bits(1500, 1'b0);
    track = 1'b0;
    chk("R7 held request starts no search", lof_hi, 0);
    chk("R7 alignment kept while held", trk_bad, 0);
    resync_req = 1'b0;
    clk_bit(1'b1);
    resync_req = 1'b1;
    clk_bit(1'b0);
    chk("R7 second edge starts search", int'(lof), 1);
    resync_req = 1'b0;
    run_bits(600, 1'b0);
    chk("R8 lof low after relock", int'(lof), 0);

    // R6: auto resync off, flywheel keeps old alignment
    auto_off = 1'b1;
    start_track(off);
    off = 77;
    kind = 2;
    run_bits(4000, 1'b0);
    track = 1'b0;
    chk("R6 no search with auto off", lof_hi, 0);
    chk("R6 flywheel keeps old alignment", trk_bad, 0);
    resync_req = 1'b1;
    clk_bit(1'b0);
    resync_req = 1'b0;
    chk("R7 manual search with auto off", int'(lof), 1);
    run_bits(800, 1'b0);
    chk("R4 lock after manual search", int'(lof), 0);
    start_track(off);
    run_bits(400, 1'b0);
    track = 1'b0;
    chk("R4 new alignment tracked", trk_bad, 0);

    // R2: disabling drops the search flag
    sync_en = 1'b0;
    resync_req = 1'b1;
    clk_bit(1'b0);
    clk_bit(1'b0);
    chk("R2 lof low when disabled", int'(lof), 0);
    resync_req = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule